// File: doc/BRIEF.md
# Dual-Reload PWM and Event Timer

This block is a down-counting timer with two reload registers, A and B. In PWM mode the hardware swaps between them on every underflow, so one register sets the high time and the other the low time, and software only steps in to change them. Each underflow can flip a driven output pin. In event-counter mode the same counter counts edges arriving on a pin instead of clock ticks.

Each reload source has its own pending flag and its own interrupt enable. Software can therefore take an interrupt on one PWM edge, on the other, or on both. In event-counter mode, a second input-only pin acts as a separate rising-edge interrupt source.

Software reaches the counter, the reloads, the control and the flags through a plain single-cycle register port. A write lands on the next clock. A read is combinational and has no side effects. The port carries no stream data, so it has no valid/ready handshake and never applies back-pressure.

Top module: `dual_reload_timer`

## Requirements
- R1: After a synchronous reset, the following are all zero: the counter, both reloads, the control register, both flags and both enables. After the same reset, `pin_a_out`, `pin_a_oe` and `irq` are low.
- R2: The register port uses these addresses:
  - Address 0 is the counter.
  - Address 1 is reload A.
  - Address 2 is reload B.
  - Address 3 is the control register: bits [2:0] mode, bit 3 toggle enable, bit 4 high-speed select.
  - Address 4 is the flag register. On read: bit 0 pending A, bit 1 pending B, bit 2 enable A, bit 3 enable B. On write: bits 3:2 load the enables, and a 1 in bit 0 or bit 1 clears that pending flag.
  - All other addresses read as zero.
  - A counter write has priority in its cycle, so no count and no underflow happen in that cycle.
- R3: Mode codes are 000 stopped, 001 PWM, 010 event on rising edge, 011 event on falling edge. Codes 100 to 111 behave as stopped. In PWM mode the counter decrements in every cycle where high-speed is 1 or `tick_en` is 1. In stopped mode it holds.
- R4: When the counter is counting and is at 0, the next count is an underflow, and an underflow reloads the counter. In PWM mode the first reload after a mode change comes from A. Later reloads come from B, A, B and so on. Any write that changes the mode restarts this sequence at A.
- R5: In PWM mode with toggle enable set, `pin_a_oe` is 1 and `pin_a_out` flips on each underflow. In every other case `pin_a_oe` is 0. Any mode change clears `pin_a_out`.
- R6: A reload from A sets pending A, and a reload from B sets pending B. A flag stays set until software clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when (pending A and enable A) or (pending B and enable B).
- R8: In event mode, `pin_a_in` passes through two synchronizer flops and an edge detector. The counter decrements in the third clock after the pin changes. In this mode every underflow reloads from A and sets pending A.
- R9: In event mode, a rising edge on `pin_b_in` (after synchronization) sets pending B. In PWM and stopped modes, `pin_b_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Low-speed count strobe for PWM mode |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pin_a_in | input | 1 | Pin A input value (event count source) |
| pin_a_out | output | 1 | Pin A output value (PWM) |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_in | input | 1 | Input-only pin, rising-edge interrupt source in event mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the counter steps down by exactly one per accepted tick and otherwise holds;
- the reload pointer alternates on PWM underflows and returns to A after a mode change;
- the output pin moves only on an underflow or a mode change, and is never driven outside PWM;
- pending flags persist and a set beats a clear;
- `irq` follows the enabled flags.

Only the bench scenarios, compared cycle by cycle against a behavioural model, can show the rest:
- the actual reload values and the B-then-A order over long runs;
- the three-cycle pin latency;
- edge polarity selection;
- the effect of `pin_b_in` being ignored outside event mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RLDA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLDB  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd4;

  typedef enum logic [2:0] {
    MODE_STOP     = 3'd0,
    MODE_PWM      = 3'd1,
    MODE_EVT_RISE = 3'd2,
    MODE_EVT_FALL = 3'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dsync,
  output logic dprev
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dprev <= 1'b0;
    else     dprev <= chain_q[STAGES-1];
  end

  assign dsync = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         seq_en,
  input  logic         seq_restart,
  input  logic [W-1:0] reload_a,
  input  logic [W-1:0] reload_b,
  output logic [W-1:0] cnt,
  output logic         uf,
  output logic         uf_from_b,
  output logic         next_a
);
  logic         step;
  logic [W-1:0] cnt_q;
  logic         next_a_q;

  assign step      = tick & ~load;
  assign uf        = step && (cnt_q == '0);
  assign uf_from_b = uf && seq_en && !next_a_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (uf)   cnt_q <= uf_from_b ? reload_b : reload_a;
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               next_a_q <= 1'b1;
    else if (seq_restart)  next_a_q <= 1'b1;
    else if (uf && seq_en) next_a_q <= ~next_a_q;
  end

  assign cnt    = cnt_q;
  assign next_a = next_a_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_a,
  input  logic       set_b,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       en_wr,
  input  logic [1:0] en_val,
  output logic       pend_a,
  output logic       pend_b,
  output logic       en_a,
  output logic       en_b,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      en_a   <= 1'b0;
      en_b   <= 1'b0;
    end else begin
      if (set_a)      pend_a <= 1'b1;
      else if (clr_a) pend_a <= 1'b0;
      if (set_b)      pend_b <= 1'b1;
      else if (clr_b) pend_b <= 1'b0;
      if (en_wr) begin
        en_a <= en_val[0];
        en_b <= en_val[1];
      end
    end
  end

  assign irq = (pend_a & en_a) | (pend_b & en_b);
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              pin_a_in,
  output logic              pin_a_out,
  output logic              pin_a_oe,
  input  logic              pin_b_in,
  output logic              irq
);
  localparam int CTRL_BITS = 5;
  localparam int FLAG_BITS = 4;

  logic [W-1:0] reload_a_q, reload_b_q, cnt;
  logic [2:0]   mode_q;
  logic         tog_en_q, hs_q, out_q;
  logic         wr_cnt, wr_rlda, wr_rldb, wr_ctrl, wr_flags, mode_chg;
  logic         is_pwm, is_evr, is_evf, is_evt;
  logic         a_s, a_d, b_s, b_d, a_rise, a_fall, b_rise;
  logic         count_tick, uf, uf_from_b, next_a;
  logic         set_a, set_b, clr_a, clr_b;
  logic         pend_a, pend_b, en_a, en_b;

  assign wr_cnt   = reg_wr && (reg_addr == ADDR_CNT);
  assign wr_rlda  = reg_wr && (reg_addr == ADDR_RLDA);
  assign wr_rldb  = reg_wr && (reg_addr == ADDR_RLDB);
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
  assign mode_chg = wr_ctrl && (reg_wdata[2:0] != mode_q);

  assign is_pwm = (mode_q == MODE_PWM);
  assign is_evr = (mode_q == MODE_EVT_RISE);
  assign is_evf = (mode_q == MODE_EVT_FALL);
  assign is_evt = is_evr | is_evf;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .din(pin_a_in), .dsync(a_s), .dprev(a_d)
  );
  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(pin_b_in), .dsync(b_s), .dprev(b_d)
  );

  assign a_rise = a_s & ~a_d;
  assign a_fall = ~a_s & a_d;
  assign b_rise = b_s & ~b_d;

  assign count_tick = (is_pwm && (hs_q || tick_en)) ||
                      (is_evr && a_rise) ||
                      (is_evf && a_fall);

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(count_tick), .load(wr_cnt), .load_val(reg_wdata),
    .seq_en(is_pwm), .seq_restart(mode_chg),
    .reload_a(reload_a_q), .reload_b(reload_b_q),
    .cnt(cnt), .uf(uf), .uf_from_b(uf_from_b), .next_a(next_a)
  );

  assign set_a = uf && !uf_from_b;
  assign set_b = uf_from_b || (is_evt && b_rise);
  assign clr_a = wr_flags && reg_wdata[0];
  assign clr_b = wr_flags && reg_wdata[1];

  tmr_flags u_flags (
    .clk(clk), .rst(rst), .set_a(set_a), .set_b(set_b), .clr_a(clr_a), .clr_b(clr_b),
    .en_wr(wr_flags), .en_val(reg_wdata[3:2]),
    .pend_a(pend_a), .pend_b(pend_b), .en_a(en_a), .en_b(en_b), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_a_q <= '0;
      reload_b_q <= '0;
      mode_q     <= MODE_STOP;
      tog_en_q   <= 1'b0;
      hs_q       <= 1'b0;
    end else begin
      if (wr_rlda) reload_a_q <= reg_wdata;
      if (wr_rldb) reload_b_q <= reg_wdata;
      if (wr_ctrl) begin
        mode_q   <= reg_wdata[2:0];
        tog_en_q <= reg_wdata[3];
        hs_q     <= reg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           out_q <= 1'b0;
    else if (mode_chg)                 out_q <= 1'b0;
    else if (is_pwm && tog_en_q && uf) out_q <= ~out_q;
  end

  assign pin_a_out = out_q;
  assign pin_a_oe  = is_pwm & tog_en_q;

  always_comb begin
    case (reg_addr)
      ADDR_CNT:   reg_rdata = cnt;
      ADDR_RLDA:  reg_rdata = reload_a_q;
      ADDR_RLDB:  reg_rdata = reload_b_q;
      ADDR_CTRL:  reg_rdata = {{(W-CTRL_BITS){1'b0}}, hs_q, tog_en_q, mode_q};
      ADDR_FLAGS: reg_rdata = {{(W-FLAG_BITS){1'b0}}, en_b, en_a, pend_b, pend_a};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   mode,
  input logic [W-1:0] cnt,
  input logic         cnt_load,
  input logic         count_tick,
  input logic         uf,
  input logic         next_a,
  input logic         mode_chg,
  input logic         pend_a,
  input logic         pend_b,
  input logic         en_a,
  input logic         en_b,
  input logic         clr_a,
  input logic         clr_b,
  input logic         set_a,
  input logic         set_b,
  input logic         pin_a_out,
  input logic         pin_a_oe,
  input logic         irq
);
  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (count_tick && !cnt_load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!count_tick && !cnt_load) |=> $stable(cnt));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (rst)
    (uf && mode == 3'd1 && !mode_chg) |=> (next_a != $past(next_a)));

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> next_a);

  assert_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd1) |-> !pin_a_oe);

  assert_out_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!uf && !mode_chg) |=> $stable(pin_a_out));

  assert_pend_a_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_a && !clr_a) |=> pend_a);

  assert_pend_b_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_b && !clr_b) |=> pend_b);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_a || set_b) |=> (pend_a || !$past(set_a)) && (pend_b || !$past(set_b)));

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_a && !en_b) |-> !irq);

  assert_irq_on_R7: assert property (@(posedge clk) disable iff (rst)
    ((pend_a && en_a) || (pend_b && en_b)) |-> irq);
endmodule

bind dual_reload_timer tmr_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .cnt(cnt), .cnt_load(wr_cnt),
  .count_tick(count_tick), .uf(uf), .next_a(next_a), .mode_chg(mode_chg),
  .pend_a(pend_a), .pend_b(pend_b), .en_a(en_a), .en_b(en_b),
  .clr_a(clr_a), .clr_b(clr_b), .set_a(set_a), .set_b(set_b),
  .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .irq(irq)
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_a_in = 1'b0;
  logic        pin_a_out, pin_a_oe;
  logic        pin_b_in = 1'b0;
  logic        irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  slow_gen = 0;
  int  cyc = 0;

  dual_reload_timer uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a_in(pin_a_in),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe), .pin_b_in(pin_b_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  logic [15:0] m_cnt, m_ra, m_rb;
  logic [2:0]  m_mode;
  bit m_tog, m_hs, m_nexta, m_out, m_pa, m_pb, m_ea, m_eb;
  bit sa0, sa1, sa2, sb0, sb1, sb2;
  bit t_ar, t_af, t_br, t_pwm, t_evt, t_tick, t_uf, t_fb, t_cw, t_chg;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ra = 0; m_rb = 0; m_mode = 0;
      m_tog = 0; m_hs = 0; m_nexta = 1; m_out = 0;
      m_pa = 0; m_pb = 0; m_ea = 0; m_eb = 0;
      sa0 = 0; sa1 = 0; sa2 = 0; sb0 = 0; sb1 = 0; sb2 = 0;
    end else begin
      t_ar  = sa1 && !sa2;
      t_af  = !sa1 && sa2;
      t_br  = sb1 && !sb2;
      t_pwm = (m_mode == 3'd1);
      t_evt = (m_mode == 3'd2) || (m_mode == 3'd3);
      t_cw  = reg_wr && reg_addr == 3'd0;
      t_chg = reg_wr && reg_addr == 3'd3 && reg_wdata[2:0] != m_mode;
      t_tick = !t_cw && ((t_pwm && (m_hs || tick_en)) ||
                         (m_mode == 3'd2 && t_ar) || (m_mode == 3'd3 && t_af));
      t_uf = t_tick && m_cnt == 0;
      t_fb = t_uf && t_pwm && !m_nexta;
      // counter
      if (t_cw) m_cnt = reg_wdata;
      else if (t_uf) m_cnt = t_fb ? m_rb : m_ra;
      else if (t_tick) m_cnt = m_cnt - 16'd1;
      if (t_uf && t_pwm) m_nexta = !m_nexta;
      if (t_uf && t_pwm && m_tog) m_out = !m_out;
      if (t_chg) begin m_nexta = 1; m_out = 0; end
      // flags
      if (reg_wr && reg_addr == 3'd4) begin
        if (reg_wdata[0]) m_pa = 0;
        if (reg_wdata[1]) m_pb = 0;
        m_ea = reg_wdata[2];
        m_eb = reg_wdata[3];
      end
      if (t_uf && !t_fb) m_pa = 1;
      if (t_fb || (t_evt && t_br)) m_pb = 1;
      // plain registers
      if (reg_wr && reg_addr == 3'd1) m_ra = reg_wdata;
      if (reg_wr && reg_addr == 3'd2) m_rb = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) begin
        m_mode = reg_wdata[2:0]; m_tog = reg_wdata[3]; m_hs = reg_wdata[4];
      end
      sa2 = sa1; sa1 = sa0; sa0 = pin_a_in;
      sb2 = sb1; sb1 = sb0; sb0 = pin_b_in;
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_ra;
      3'd2: return m_rb;
      3'd3: return {11'd0, m_hs, m_tog, m_mode};
      3'd4: return {12'd0, m_eb, m_ea, m_pb, m_pa};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison of the pins, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (slow_gen) tick_en <= (cyc % 3 == 0);
    else          tick_en <= 1'b0;
    if (!rst && !done) begin
      check("R5", "pin_a_out", {15'd0, pin_a_out}, {15'd0, m_out});
      check("R5", "pin_a_oe",  {15'd0, pin_a_oe},  {15'd0, (m_mode == 3'd1) && m_tog});
      check("R7", "irq",       {15'd0, irq},       {15'd0, (m_pa && m_ea) || (m_pb && m_eb)});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    reg_addr = a;
    #1;
    check(req, $sformatf("read addr %0d", a), reg_rdata, model_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip_a(input int gap);
    pin_a_in = ~pin_a_in;
    idle(gap);
    rd("R8", 3'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", a[2:0]);
    check("R1", "irq after reset", {15'd0, irq}, 16'd0);
    check("R1", "pin_a_out after reset", {15'd0, pin_a_out}, 16'd0);

    // R2 register access and R4/R5/R6 fast PWM
    wr(3'd1, 16'd3); wr(3'd2, 16'd5); wr(3'd0, 16'd2);
    rd("R2", 3'd1); rd("R2", 3'd2); rd("R2", 3'd0);
    wr(3'd4, 16'b0100);
    wr(3'd3, 16'b11001);
    rd("R2", 3'd3);
    for (int i = 0; i < 30; i++) begin idle(1); rd("R4", 3'd0); end
    rd("R6", 3'd4);
    // R9 pin B ignored in PWM
    wr(3'd4, 16'b1011);
    pin_b_in = 1'b1; idle(5); pin_b_in = 1'b0;
    rd("R9", 3'd4);
    idle(15); rd("R6", 3'd4);

    // R3 low-speed counting
    wr(3'd3, 16'b01001);
    slow_gen = 1;
    for (int i = 0; i < 40; i++) begin idle(1); rd("R3", 3'd0); end
    slow_gen = 0;

    // R3 stopped, R4 restart after mode change
    wr(3'd3, 16'b11000);
    idle(3); rd("R3", 3'd0);
    wr(3'd0, 16'd1);
    wr(3'd3, 16'b11001);
    for (int i = 0; i < 12; i++) begin idle(1); rd("R4", 3'd0); end
    // R2 counter write beats the count
    wr(3'd0, 16'd7); rd("R2", 3'd0);
    // reserved mode behaves as stopped
    wr(3'd3, 16'b10101);
    idle(5); rd("R3", 3'd0);

    // R6 set and clear colliding
    wr(3'd3, 16'b10001);
    for (int k = 0; k < 8; k++) begin
      wr(3'd4, 16'b1111);
      idle(k);
      rd("R6", 3'd4);
    end

    // R8 event on rising edge, R9 pin B
    wr(3'd1, 16'd2); wr(3'd0, 16'd1); wr(3'd4, 16'b1011);
    wr(3'd3, 16'b00010);
    for (int i = 0; i < 10; i++) flip_a(4);
    pin_b_in = 1'b1; idle(4); rd("R9", 3'd4); pin_b_in = 1'b0; idle(3);
    // back-to-back pin changes checked every cycle
    for (int i = 0; i < 6; i++) begin pin_a_in = ~pin_a_in; idle(1); rd("R8", 3'd0); end
    idle(4);

    // R8 event on falling edge
    wr(3'd4, 16'b0111);
    wr(3'd3, 16'b00011);
    for (int i = 0; i < 10; i++) flip_a(3);
    rd("R8", 3'd4);
    rd("R2", 3'd6);

    idle(2);
    finish_run();
  end
endmodule